// File: doc/BRIEF.md
# Scalar Conditional Branch Unit

This block computes the next program counter for the relative branches of a wide-SIMD processor's scalar pipe. When a branch is presented, the block reads a 3-bit branch kind, the current byte address, a signed 16-bit word offset, a scalar condition flag, a per-lane vector condition mask and a per-lane execution mask. It decides whether the branch is taken and forms the following address. The result appears one clock later, together with a one-cycle valid pulse.

The word offset is scaled to bytes by a left shift of two. The scaled value is treated as an 18-bit signed quantity, so offsets in the upper half of the positive range move forward and do not wrap backward. Fetch, pipeline flush and the logic that produces the condition values sit outside this block.

Top module: `scalarBranchUnit`

## Requirements
- R1: The byte displacement is the 16-bit immediate shifted left by two bits. This 18-bit result is sign-extended from bit 17 to 64 bits. For example, immediate 0x4000 gives +0x10000, and immediate 0x8000 gives -0x20000.
- R2: A taken branch produces nextPc = curPc + 4 + displacement. Immediate 0xFFFF (-1) therefore yields nextPc equal to curPc.
- R3: A branch that is not taken produces nextPc = curPc + 4 and taken = 0.
- R4: Kind code 0 (always) is taken whatever the conditions are.
- R5: Kind code 1 is taken when sccBit is 0. Kind code 2 is taken when sccBit is 1.
- R6: Kind code 3 is taken when all 64 bits of vccMask are zero. Kind code 4 is taken when any bit of vccMask is set.
- R7: Kind code 5 is taken when execMask is all zero. Kind code 6 is taken when any lane of execMask is active.
- R8: Kind code 7 is reserved. It is never taken and produces curPc + 4.
- R9: Address arithmetic wraps modulo 2^64.
- R10: Inputs are sampled at a clock edge where inValid is 1. nextPc and taken update at that edge, and outValid is 1 for exactly the following cycle. Back-to-back valid inputs give back-to-back results.
- R11: A synchronous active-high reset clears outValid, taken and nextPc to 0. Inputs presented during reset are discarded.
- R12: At an edge where inValid is 0, nextPc and taken keep their previous values, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Branch present this cycle |
| brType | input | 3 | Branch kind code (0 to 7) |
| curPc | input | 64 | Byte address of the branch |
| imm | input | 16 | Signed word offset |
| sccBit | input | 1 | Scalar condition flag |
| vccMask | input | 64 | Per-lane vector condition mask |
| execMask | input | 64 | Per-lane execution mask |
| nextPc | output | 64 | Registered next address |
| taken | output | 1 | Registered taken flag |
| outValid | output | 1 | One-cycle pulse marking a fresh result |

## Verification
The bench builds the block with its default parameters: a 64-bit address, a 16-bit immediate, a shift of two and 64 lanes. These values make the bit-17 extension boundary reachable from immediates 0x4000 to 0x7FFF and 0x8000 to 0xBFFF. They also expose wrap-around at the top of the 64-bit space and a mask that is empty apart from lane 63. Random streams mix valid and idle cycles and give the masks a strong bias toward zero, so every condition kind is exercised in both its taken and its not-taken sense.

// File: rtl/brPkg.sv
package brPkg;

  localparam int SEL_W = 3;

  typedef enum logic [SEL_W-1:0] {
    BR_ALWAYS     = 3'd0,
    BR_FLAG_CLR   = 3'd1,
    BR_FLAG_SET   = 3'd2,
    BR_VMASK_ZERO = 3'd3,
    BR_VMASK_ANY  = 3'd4,
    BR_LANES_NONE = 3'd5,
    BR_LANES_ANY  = 3'd6,
    BR_RESERVED   = 3'd7
  } brKind_e;

  // strobes passed from control to datapath
  typedef struct packed {
    logic capture;  // latch a new result this edge
    logic take;     // select the branch target
  } brStrobe_t;

endpackage

// File: rtl/brControl.sv
module brControl
  import brPkg::*;
#(
  parameter int MASK_W = 64
) (
  input  logic              inValid,
  input  logic [SEL_W-1:0]  brType,
  input  logic              sccBit,
  input  logic [MASK_W-1:0] vccMask,
  input  logic [MASK_W-1:0] execMask,
  output brStrobe_t         strobe
);

  brKind_e kind;
  logic    vmaskAny;
  logic    lanesAny;
  logic    cond;

  always_comb begin
    kind     = brKind_e'(brType);
    vmaskAny = |vccMask;
    lanesAny = |execMask;
    case (kind)
      BR_ALWAYS:     cond = 1'b1;
      BR_FLAG_CLR:   cond = ~sccBit;
      BR_FLAG_SET:   cond = sccBit;
      BR_VMASK_ZERO: cond = ~vmaskAny;
      BR_VMASK_ANY:  cond = vmaskAny;
      BR_LANES_NONE: cond = ~lanesAny;
      BR_LANES_ANY:  cond = lanesAny;
      BR_RESERVED:   cond = 1'b0;
      default:       cond = 1'b0;
    endcase
    strobe.capture = inValid;
    strobe.take    = inValid & cond;
  end

endmodule

// File: rtl/brDatapath.sv
module brDatapath
  import brPkg::*;
#(
  parameter int PC_W  = 64,
  parameter int IMM_W = 16,
  parameter int SHIFT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  brStrobe_t        strobe,
  input  logic [PC_W-1:0]  curPc,
  input  logic [IMM_W-1:0] imm,
  output logic [PC_W-1:0]  nextPc,
  output logic             taken,
  output logic             outValid
);

  localparam int DISP_W     = IMM_W + SHIFT;
  localparam int EXT_W      = PC_W - DISP_W;
  localparam int WORD_BYTES = 1 << SHIFT;

  logic [DISP_W-1:0] scaled;
  logic [PC_W-1:0]   disp;
  logic [PC_W-1:0]   seqPc;
  logic [PC_W-1:0]   chosenPc;

  always_comb begin
    scaled   = {imm, {SHIFT{1'b0}}};
    disp     = {{EXT_W{scaled[DISP_W-1]}}, scaled};
    seqPc    = curPc + PC_W'(WORD_BYTES);
    chosenPc = strobe.take ? (seqPc + disp) : seqPc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      taken    <= 1'b0;
      nextPc   <= '0;
    end else begin
      outValid <= strobe.capture;
      if (strobe.capture) begin
        taken  <= strobe.take;
        nextPc <= chosenPc;
      end
    end
  end

endmodule

// File: rtl/scalarBranchUnit.sv
module scalarBranchUnit
  import brPkg::*;
#(
  parameter int PC_W   = 64,
  parameter int IMM_W  = 16,
  parameter int SHIFT  = 2,
  parameter int MASK_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [SEL_W-1:0]  brType,
  input  logic [PC_W-1:0]   curPc,
  input  logic [IMM_W-1:0]  imm,
  input  logic              sccBit,
  input  logic [MASK_W-1:0] vccMask,
  input  logic [MASK_W-1:0] execMask,
  output logic [PC_W-1:0]   nextPc,
  output logic              taken,
  output logic              outValid
);

  brStrobe_t strobe;

  brControl #(.MASK_W(MASK_W)) uCtrl (
    .inValid (inValid),
    .brType  (brType),
    .sccBit  (sccBit),
    .vccMask (vccMask),
    .execMask(execMask),
    .strobe  (strobe)
  );

  brDatapath #(.PC_W(PC_W), .IMM_W(IMM_W), .SHIFT(SHIFT)) uDp (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .curPc   (curPc),
    .imm     (imm),
    .nextPc  (nextPc),
    .taken   (taken),
    .outValid(outValid)
  );

endmodule

// File: rtl/scalarBranchUnitChk.sv
module scalarBranchUnitChk #(
  parameter int PC_W   = 64,
  parameter int MASK_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              inValid,
  input logic [2:0]        brType,
  input logic [PC_W-1:0]   curPc,
  input logic [MASK_W-1:0] execMask,
  input logic [PC_W-1:0]   nextPc,
  input logic              taken,
  input logic              outValid
);

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R11
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!outValid && !taken));

  // R12
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(nextPc) && $stable(taken)));

  // R3
  fallthrough_pc_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && !taken) |-> (nextPc == $past(curPc) + PC_W'(4)));

  // R4
  always_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && brType == 3'd0) |=> taken);

  // R8
  reserved_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && brType == 3'd7) |=> !taken);

  // R7
  lanes_cond_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && brType == 3'd6) |=> (taken == ($past(execMask) != '0)));

endmodule

bind scalarBranchUnit scalarBranchUnitChk #(.PC_W(PC_W), .MASK_W(MASK_W)) uChk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .brType  (brType),
  .curPc   (curPc),
  .execMask(execMask),
  .nextPc  (nextPc),
  .taken   (taken),
  .outValid(outValid)
);

// File: tb/sim_scalarBranchUnit.sv
module sim_scalarBranchUnit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [2:0]  brType = '0;
  logic [63:0] curPc = '0;
  logic [15:0] imm = '0;
  logic        sccBit = 1'b0;
  logic [63:0] vccMask = '0;
  logic [63:0] execMask = '0;
  logic [63:0] nextPc;
  logic        taken;
  logic        outValid;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  logic        mValid = 1'b0;
  logic        mTaken = 1'b0;
  logic [63:0] mPc    = '0;
  string       curTag = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  scalarBranchUnit u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .brType(brType), .curPc(curPc),
    .imm(imm), .sccBit(sccBit), .vccMask(vccMask), .execMask(execMask),
    .nextPc(nextPc), .taken(taken), .outValid(outValid)
  );

  function automatic logic expTake(input logic [2:0] k, input logic s,
                                   input logic [63:0] vm, input logic [63:0] em);
    case (k)
      3'd0: return 1'b1;
      3'd1: return s == 1'b0;
      3'd2: return s == 1'b1;
      3'd3: return vm == 64'd0;
      3'd4: return vm != 64'd0;
      3'd5: return em == 64'd0;
      3'd6: return em != 64'd0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [63:0] expPc(input logic [63:0] pc, input logic [15:0] im,
                                        input logic tk);
    longint off;
    off = longint'(shortint'(im)) * 64'sd4;
    return tk ? (pc + 64'd4 + 64'(off)) : (pc + 64'd4);
  endfunction

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual %h expected %h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  // check the result of the previous cycle, then present new inputs
  task automatic step(input logic v, input logic [2:0] k, input logic [63:0] pc,
                      input logic [15:0] im, input logic s, input logic [63:0] vm,
                      input logic [63:0] em, input string tag);
    logic t;
    @(negedge clk);
    chk({curTag, " outValid"}, 64'(outValid), 64'(mValid));
    chk({curTag, " nextPc"}, nextPc, mPc);
    chk({curTag, " taken"}, 64'(taken), 64'(mTaken));
    rst = 1'b0;
    inValid = v; brType = k; curPc = pc; imm = im;
    sccBit = s; vccMask = vm; execMask = em;
    curTag = tag;
    mValid = v;
    if (v) begin
      t = expTake(k, s, vm, em);
      mTaken = t;
      mPc = expPc(pc, im, t);
    end
  endtask

  task automatic resetPulse();
    @(negedge clk);
    chk({curTag, " outValid"}, 64'(outValid), 64'(mValid));
    chk({curTag, " nextPc"}, nextPc, mPc);
    chk({curTag, " taken"}, 64'(taken), 64'(mTaken));
    rst = 1'b1;
    inValid = 1'b1; brType = 3'd0; curPc = 64'h1234; imm = 16'h0010;
    curTag = "R11 mid-run reset";
    mValid = 1'b0; mTaken = 1'b0; mPc = '0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual %0d expected below 100000", cycles);
      summary();
    end
  end

  initial begin
    void'($urandom(32'd2024));
    // reset state observed by the first step
    step(1, 3'd0, 64'h1000, 16'h4000, 0, '0, '0, "R1 +0x10000 not negative");
    step(1, 3'd0, 64'h100000, 16'h8000, 0, '0, '0, "R1 most negative");
    step(1, 3'd0, 64'h2000, 16'h7FFF, 0, '0, '0, "R1 most positive");
    step(1, 3'd0, 64'h2000, 16'hBFFF, 0, '0, '0, "R1 bit17 set");
    step(1, 3'd0, 64'h5550, 16'hFFFF, 0, '0, '0, "R2 minus one");
    step(1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFC, 16'h0000, 1, '1, '1, "R9 top wrap");
    step(1, 3'd0, 64'h0, 16'hFFFE, 0, '0, '0, "R9 bottom wrap");
    step(1, 3'd1, 64'h300, 16'h0020, 0, '0, '0, "R5 flag clear taken");
    step(1, 3'd1, 64'h300, 16'h0020, 1, '0, '0, "R5 flag clear not taken R3");
    step(1, 3'd2, 64'h300, 16'h0020, 1, '0, '0, "R5 flag set taken");
    step(1, 3'd2, 64'h300, 16'h0020, 0, '0, '0, "R5 flag set not taken R3");
    step(1, 3'd3, 64'h400, 16'hFFF0, 0, '0, '1, "R6 vmask zero taken");
    step(1, 3'd3, 64'h400, 16'hFFF0, 0, 64'h8000_0000_0000_0000, '0, "R6 vmask zero lane63");
    step(1, 3'd4, 64'h400, 16'hFFF0, 0, 64'h8000_0000_0000_0000, '0, "R6 vmask any lane63");
    step(1, 3'd4, 64'h400, 16'hFFF0, 0, '0, '1, "R6 vmask any empty");
    step(1, 3'd5, 64'h500, 16'h0100, 0, '1, '0, "R7 lanes none taken");
    step(1, 3'd5, 64'h500, 16'h0100, 0, '0, 64'h1, "R7 lanes none lane0");
    step(1, 3'd6, 64'h500, 16'h0100, 0, '0, 64'h1, "R7 lanes any lane0");
    step(1, 3'd6, 64'h500, 16'h0100, 1, '1, '0, "R7 lanes any empty");
    step(1, 3'd7, 64'h600, 16'h0040, 0, '0, '0, "R8 reserved zeros");
    step(1, 3'd7, 64'h600, 16'h0040, 1, '1, '1, "R8 reserved ones");
    step(1, 3'd0, 64'h700, 16'h0008, 0, '0, '0, "R10 back to back");
    step(0, 3'd7, 64'h9999, 16'hFFFF, 1, '1, '0, "R12 idle reserved");
    step(0, 3'd0, 64'h8888, 16'h1234, 0, '0, '0, "R12 idle always");
    resetPulse();
    step(0, 3'd0, 64'h0, 16'h0, 0, '0, '0, "R12 idle after reset");
    for (int i = 0; i < 400; i++) begin
      logic [2:0]  k;
      logic [63:0] vm;
      logic [63:0] em;
      k  = 3'($urandom_range(0, 7));
      vm = ($urandom_range(0, 2) == 0) ? 64'd0 :
           (($urandom_range(0, 1) == 0) ? (64'd1 << $urandom_range(0, 63))
                                        : {$urandom, $urandom});
      em = ($urandom_range(0, 2) == 0) ? 64'd0 :
           (($urandom_range(0, 1) == 0) ? (64'd1 << $urandom_range(0, 63))
                                        : {$urandom, $urandom});
      step(($urandom_range(0, 3) != 0), k, {$urandom, $urandom}, 16'($urandom),
           1'($urandom), vm, em, "R10 random stream R1 R2 R3");
    end
    step(0, 3'd0, '0, '0, 0, '0, '0, "R12 drain");
    summary();
  end

endmodule